// File: doc/BRIEF.md
# Segmented RAM Write Protection Checker

This block sits beside a RAM write path and decides, in the same cycle as the write, whether that write may proceed. Two programmable segments each hold a word-granular lower bound and upper bound. Each segment also holds one enable bit per protected address space. One enable bit covers user-data writes and the other covers supervisor-data writes. A policy input selects between two modes. In block mode the enabled segments are forbidden windows. In allow mode they are the only windows a write may land in.

Software programs the segments through a small register port and can read them back. A write that sets bits outside a register's legal fields raises a register-error pulse, and the legal fields are stored anyway. On the check side the caller presents the byte address, the address-space code and the access size. The block answers with a fault pulse and a gated memory write-enable. Checking is dormant while every segment's enable field is zero.

Top module: `segwp_unit`

## Requirements
- R1: After a synchronous active-low reset, every segment's lower bound, upper bound and enable field read back as zero.
- R2: The register selector is 2 bits: 0 = segment 0 lower bound, 1 = segment 0 upper bound, 2 = segment 1 lower bound, 3 = segment 1 upper bound. A write to a lower-bound register stores data bits 22:0 as the bound and bits 24:23 as the enable field. Reading it returns both in those same bit positions, with all other bits zero.
- R3: A write to an upper-bound register stores data bits 22:0. Reading it returns that value with bits 31:23 zero.
- R4: In the cycle of a register write, `cfg_err` is high exactly when any of bits 31:25 are set on a lower-bound write, or any of bits 31:23 are set on an upper-bound write. The legal fields are still stored.
- R5: The word address compared against the bounds is byte-address bits 22:2. Byte-address bits 31:23 and 1:0 have no effect.
- R6: Enable bit 0 applies to space code 0x0A (user data) and enable bit 1 applies to space code 0x0B (supervisor data). A write with any other space code hits no segment.
- R7: A segment is hit when its enable bit for the space is set, the word address is at least the lower bound, and the word address is strictly below the upper bound. For size code 3 (double word) the word address is ORed with 1 before the upper-bound compare. Size codes 0, 1 and 2 (byte, half, word) use it unchanged.
- R8: With `block_mode` high, a checked write faults when it hits any segment.
- R9: With `block_mode` low, a checked write faults unless it hits at least one segment.
- R10: While every segment's enable field is zero, no write faults in either mode.
- R11: `chk_fault` is high only in a cycle with `chk_valid` high, and it is combinational with the check inputs. `mem_we` equals `chk_valid` with `chk_fault` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector (R2 encoding) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| cfg_err | output | 1 | Illegal-bit pulse for the current register write |
| block_mode | input | 1 | 1: segments forbid writes, 0: segments are the only allowed areas |
| chk_valid | input | 1 | A RAM write is presented for checking |
| chk_addr | input | 32 | Byte address of the write |
| chk_space | input | 8 | Address-space code of the write |
| chk_size | input | 2 | 0 byte, 1 half, 2 word, 3 double word |
| chk_fault | output | 1 | Protection fault for the presented write |
| mem_we | output | 1 | Write-enable passed on to the RAM |

## Verification
Two functions can meet in one cycle: a register write that changes a bound, and a write check that compares against that bound. The directed bench rewrites a segment's upper bound so that a double-word access sits exactly on the new boundary. It then presents both word and double-word checks in the following cycles. The result is judged against the bound that was stored at the preceding edge, because the register update takes effect only at the clock edge. The parity pulse is checked in the same cycle as the write, and the legal fields are read back afterwards.

// File: rtl/segwp_pkg.sv
// Shared definitions for the segmented write-protection checker.
// Assumes address-space codes are 8 bits wide and that enable bit i
// of a segment belongs to SPACE_CODE[i].
package segwp_pkg;

    // Access size codes presented on the check port
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int SPACE_W = 8;
    localparam int NUM_SPACES = 2;

    // Space code guarded by each enable bit (index = enable bit)
    localparam logic [SPACE_W-1:0] SPACE_CODE [NUM_SPACES] = '{8'h0A, 8'h0B};

endpackage

// File: rtl/segwp_regs.sv
// Segment register bank.
// Holds lower bound, upper bound and enable field for each segment,
// serves read-back, and flags writes that set bits outside legal fields.
// Assumes cfg_sel[0] chooses upper (1) or lower (0) bound and the
// remaining selector bits choose the segment.
module segwp_regs #(
    parameter int NUM_SEG = 2,
    parameter int ADDR_W  = 23,
    parameter int EN_W    = 2,
    parameter int DATA_W  = 32,
    localparam int SEL_W  = $clog2(NUM_SEG) + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [SEL_W-1:0]                sel,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic                            perr,
    output logic [NUM_SEG-1:0][ADDR_W-1:0]  seg_lo,
    output logic [NUM_SEG-1:0][ADDR_W-1:0]  seg_hi,
    output logic [NUM_SEG-1:0][EN_W-1:0]    seg_en
);

    localparam int IDX_W = SEL_W - 1;

    logic              is_hi;
    logic [IDX_W-1:0]  idx;

    assign is_hi = sel[0];
    assign idx   = sel[SEL_W-1:1];

    // Storage for each segment, written when the selector addresses it
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_lo[g] <= '0;
                seg_hi[g] <= '0;
                seg_en[g] <= '0;
            end else if (wr && idx == IDX_W'(g)) begin
                if (is_hi) begin
                    seg_hi[g] <= wdata[ADDR_W-1:0];
                end else begin
                    seg_lo[g] <= wdata[ADDR_W-1:0];
                    seg_en[g] <= wdata[ADDR_W+EN_W-1:ADDR_W];
                end
            end
        end
    end

    // Read-back mux; unused selector codes return zero
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (idx == IDX_W'(s)) begin
                if (is_hi) begin
                    rdata[ADDR_W-1:0] = seg_hi[s];
                end else begin
                    rdata[ADDR_W-1:0]             = seg_lo[s];
                    rdata[ADDR_W+EN_W-1:ADDR_W]   = seg_en[s];
                end
            end
        end
    end

    // Illegal-bit detection for the write in progress
    always_comb begin
        if (!wr)
            perr = 1'b0;
        else if (is_hi)
            perr = |wdata[DATA_W-1:ADDR_W];
        else
            perr = |wdata[DATA_W-1:ADDR_W+EN_W];
    end

endmodule

// File: rtl/segwp_match.sv
// Single-segment range match.
// Picks the enable bit for the access space, then compares the word
// address against the bounds; the upper compare uses the address with
// bit 0 forced high for double-word accesses.
module segwp_match
    import segwp_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int EN_W   = 2
) (
    input  logic [ADDR_W-1:0]  lo,
    input  logic [ADDR_W-1:0]  hi,
    input  logic [EN_W-1:0]    en,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic               dword,
    input  logic [SPACE_W-1:0] space,
    output logic               hit
);

    logic              space_en;
    logic [ADDR_W-1:0] top_word;

    // Enable bit belonging to the presented address space
    always_comb begin
        space_en = 1'b0;
        for (int i = 0; i < EN_W && i < NUM_SPACES; i++) begin
            if (space == SPACE_CODE[i])
                space_en = space_en | en[i];
        end
    end

    assign top_word = waddr | ADDR_W'(dword);

    // Range test: inclusive lower, exclusive upper
    assign hit = space_en && (waddr >= lo) && (top_word < hi);

endmodule

// File: rtl/segwp_policy.sv
// Fault policy.
// Combines segment hits with the mode input and the global activity
// condition, and gates the write-enable toward memory.
module segwp_policy #(
    parameter int NUM_SEG = 2,
    parameter int EN_W    = 2
) (
    input  logic                          valid,
    input  logic                          block_mode,
    input  logic [NUM_SEG-1:0]            hits,
    input  logic [NUM_SEG-1:0][EN_W-1:0]  seg_en,
    output logic                          fault,
    output logic                          we
);

    logic active;
    logic any_hit;

    assign active  = |seg_en;
    assign any_hit = |hits;

    // Block mode forbids hits; allow mode forbids misses
    always_comb begin
        if (!valid || !active)
            fault = 1'b0;
        else if (block_mode)
            fault = any_hit;
        else
            fault = !any_hit;
    end

    // Write reaches memory only when not faulted
    assign we = valid && !fault;

endmodule

// File: rtl/segwp_unit.sv
// Segmented RAM write-protection unit (top).
// Register bank for the segments, one range matcher per segment and a
// policy stage. The check path is purely combinational so the fault and
// the suppressed write-enable line up with the presented write.
module segwp_unit
    import segwp_pkg::*;
#(
    parameter int NUM_SEG = 2,
    parameter int ADDR_W  = 23,
    parameter int EN_W    = 2,
    parameter int DATA_W  = 32,
    parameter int BYTE_W  = 23,
    localparam int SEL_W  = $clog2(NUM_SEG) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output logic               cfg_err,
    input  logic               block_mode,
    input  logic               chk_valid,
    input  logic [DATA_W-1:0]  chk_addr,
    input  logic [SPACE_W-1:0] chk_space,
    input  logic [1:0]         chk_size,
    output logic               chk_fault,
    output logic               mem_we
);

    localparam int PAD_W = ADDR_W - (BYTE_W - 2);

    logic [NUM_SEG-1:0][ADDR_W-1:0] seg_lo;
    logic [NUM_SEG-1:0][ADDR_W-1:0] seg_hi;
    logic [NUM_SEG-1:0][EN_W-1:0]   seg_en;
    logic [NUM_SEG-1:0]             hits;
    logic [ADDR_W-1:0]              waddr;
    logic                           dword;

    // Word address from the masked byte address
    assign waddr = {{PAD_W{1'b0}}, chk_addr[BYTE_W-1:2]};
    assign dword = (chk_size == SZ_DWORD);

    segwp_regs #(
        .NUM_SEG (NUM_SEG),
        .ADDR_W  (ADDR_W),
        .EN_W    (EN_W),
        .DATA_W  (DATA_W)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .perr   (cfg_err),
        .seg_lo (seg_lo),
        .seg_hi (seg_hi),
        .seg_en (seg_en)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_match
        segwp_match #(
            .ADDR_W (ADDR_W),
            .EN_W   (EN_W)
        ) match_i (
            .lo    (seg_lo[g]),
            .hi    (seg_hi[g]),
            .en    (seg_en[g]),
            .waddr (waddr),
            .dword (dword),
            .space (chk_space),
            .hit   (hits[g])
        );
    end

    segwp_policy #(
        .NUM_SEG (NUM_SEG),
        .EN_W    (EN_W)
    ) policy_i (
        .valid      (chk_valid),
        .block_mode (block_mode),
        .hits       (hits),
        .seg_en     (seg_en),
        .fault      (chk_fault),
        .we         (mem_we)
    );

endmodule

// File: rtl/segwp_checker.sv
// Property checker for segwp_unit, attached by bind.
// Observes ports and the stored segment fields.
module segwp_checker
    import segwp_pkg::*;
#(
    parameter int NUM_SEG = 2,
    parameter int ADDR_W  = 23,
    parameter int EN_W    = 2,
    parameter int DATA_W  = 32,
    localparam int SEL_W  = $clog2(NUM_SEG) + 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_wr,
    input logic [SEL_W-1:0]               cfg_sel,
    input logic [DATA_W-1:0]              cfg_wdata,
    input logic                           cfg_err,
    input logic                           block_mode,
    input logic                           chk_valid,
    input logic [SPACE_W-1:0]             chk_space,
    input logic                           chk_fault,
    input logic                           mem_we,
    input logic [NUM_SEG-1:0][ADDR_W-1:0] seg_lo,
    input logic [NUM_SEG-1:0][ADDR_W-1:0] seg_hi,
    input logic [NUM_SEG-1:0][EN_W-1:0]   seg_en
);

    logic foreign_space;
    assign foreign_space = (chk_space != SPACE_CODE[0]) && (chk_space != SPACE_CODE[1]);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (seg_lo == '0 && seg_hi == '0 && seg_en == '0)); // R1

    AST_LO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == '0) |=>
            (seg_lo[0] == $past(cfg_wdata[ADDR_W-1:0]) &&
             seg_en[0] == $past(cfg_wdata[ADDR_W+EN_W-1:ADDR_W]))); // R2

    AST_ERR_KEEPS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && cfg_sel == SEL_W'(1)) |=>
            (seg_hi[0] == $past(cfg_wdata[ADDR_W-1:0]))); // R4

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_wr); // R4

    AST_FOREIGN_SPACE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (block_mode && foreign_space) |-> !chk_fault); // R6

    AST_DORMANT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en == '0) |-> !chk_fault); // R10

    AST_FAULT_GATES_WE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fault |-> (chk_valid && !mem_we)); // R11

    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> (!mem_we && !chk_fault)); // R11

endmodule

bind segwp_unit segwp_checker #(
    .NUM_SEG (NUM_SEG),
    .ADDR_W  (ADDR_W),
    .EN_W    (EN_W),
    .DATA_W  (DATA_W)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_err    (cfg_err),
    .block_mode (block_mode),
    .chk_valid  (chk_valid),
    .chk_space  (chk_space),
    .chk_fault  (chk_fault),
    .mem_we     (mem_we),
    .seg_lo     (seg_lo),
    .seg_hi     (seg_hi),
    .seg_en     (seg_en)
);

// File: tb/segwp_unit_tb.sv
// Directed bench for segwp_unit: one task per scenario.
module segwp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        block_mode;
    logic        chk_valid;
    logic [31:0] chk_addr;
    logic [7:0]  chk_space;
    logic [1:0]  chk_size;
    logic        chk_fault;
    logic        mem_we;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [7:0] SP_USR = 8'h0A;
    localparam logic [7:0] SP_SUP = 8'h0B;

    always #10 clk = ~clk;

    segwp_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .block_mode (block_mode),
        .chk_valid  (chk_valid),
        .chk_addr   (chk_addr),
        .chk_space  (chk_space),
        .chk_size   (chk_size),
        .chk_fault  (chk_fault),
        .mem_we     (mem_we)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data,
                             input logic exp_err, input string tag);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        #1 check(tag, 32'(cfg_err), 32'(exp_err));
        @(posedge clk);
        #1 cfg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel;
        #1 check(tag, cfg_rdata, exp);
    endtask

    task automatic wr_check(input logic [7:0] sp, input logic [31:0] addr,
                            input logic [1:0] sz, input logic exp_fault, input string tag);
        @(negedge clk);
        chk_valid = 1'b1; chk_space = sp; chk_addr = addr; chk_size = sz;
        #1;
        check(tag, 32'(chk_fault), 32'(exp_fault));
        check({tag, " R11 we"}, 32'(mem_we), 32'(!exp_fault));
        @(posedge clk);
        #1 chk_valid = 1'b0;
    endtask

    task automatic t_reset;
        reg_read(2'd0, 32'h0, "R1 seg0 lower");
        reg_read(2'd1, 32'h0, "R1 seg0 upper");
        reg_read(2'd2, 32'h0, "R1 seg1 lower");
        reg_read(2'd3, 32'h0, "R1 seg1 upper");
        block_mode = 1'b0;
        wr_check(SP_USR, 32'h40, 2'd2, 1'b0, "R10 dormant after reset");
    endtask

    task automatic t_regs;
        reg_write(2'd0, 32'h0080_0010, 1'b0, "R4 legal lower");
        reg_write(2'd1, 32'h0000_0020, 1'b0, "R4 legal upper");
        reg_write(2'd2, 32'h0100_0100, 1'b0, "R4 legal lower seg1");
        reg_write(2'd3, 32'h0000_0200, 1'b0, "R4 legal upper seg1");
        reg_read(2'd0, 32'h0080_0010, "R2 seg0 lower readback");
        reg_read(2'd1, 32'h0000_0020, "R3 seg0 upper readback");
        reg_read(2'd2, 32'h0100_0100, "R2 seg1 lower readback");
        reg_read(2'd3, 32'h0000_0200, "R3 seg1 upper readback");
    endtask

    task automatic t_block;
        block_mode = 1'b1;
        wr_check(SP_USR, 32'h0000_0040, 2'd2, 1'b1, "R8 lower bound hit");
        wr_check(SP_USR, 32'h0000_003C, 2'd2, 1'b0, "R7 below lower bound");
        wr_check(SP_USR, 32'h0000_007C, 2'd0, 1'b1, "R8 last word hit");
        wr_check(SP_USR, 32'h0000_0080, 2'd2, 1'b0, "R7 upper bound exclusive");
        wr_check(SP_USR, 32'hFF80_0043, 2'd0, 1'b1, "R5 high bits ignored");
        wr_check(SP_SUP, 32'h0000_0040, 2'd2, 1'b0, "R6 sup not enabled seg0");
        wr_check(SP_SUP, 32'h0000_0400, 2'd2, 1'b1, "R6 sup hits seg1");
        wr_check(8'h09,  32'h0000_0400, 2'd2, 1'b0, "R6 foreign space");
    endtask

    task automatic t_allow;
        block_mode = 1'b0;
        wr_check(SP_USR, 32'h0000_0040, 2'd2, 1'b0, "R9 inside allowed");
        wr_check(SP_USR, 32'h0000_0080, 2'd2, 1'b1, "R9 outside allowed");
        wr_check(SP_SUP, 32'h0000_0040, 2'd2, 1'b1, "R9 sup outside seg1");
        wr_check(SP_SUP, 32'h0000_07FC, 2'd2, 1'b0, "R9 sup top of seg1");
        wr_check(8'h09,  32'h0000_0040, 2'd2, 1'b1, "R6 foreign space allow");
    endtask

    task automatic t_dword;
        block_mode = 1'b1;
        reg_write(2'd1, 32'h0000_001F, 1'b0, "R4 shrink upper");
        wr_check(SP_USR, 32'h0000_0078, 2'd2, 1'b1, "R7 word below new bound");
        wr_check(SP_USR, 32'h0000_0078, 2'd3, 1'b0, "R7 dword crosses bound");
        wr_check(SP_USR, 32'h0000_0070, 2'd3, 1'b1, "R7 dword inside");
    endtask

    task automatic t_parity;
        reg_write(2'd1, 32'h0080_0025, 1'b1, "R4 upper bit23 illegal");
        reg_read(2'd1, 32'h0000_0025, "R4 upper legal part kept");
        reg_write(2'd0, 32'h0380_0005, 1'b1, "R4 lower bit25 illegal");
        reg_read(2'd0, 32'h0180_0005, "R4 lower legal part kept");
        reg_write(2'd0, 32'h0180_0006, 1'b0, "R4 bit24 legal on lower");
        reg_write(2'd3, 32'h8000_0200, 1'b1, "R4 upper bit31 illegal");
    endtask

    task automatic t_dormant;
        reg_write(2'd0, 32'h0000_0010, 1'b0, "R10 clear en seg0");
        reg_write(2'd2, 32'h0000_0100, 1'b0, "R10 clear en seg1");
        block_mode = 1'b0;
        wr_check(SP_USR, 32'h0000_0040, 2'd2, 1'b0, "R10 allow mode dormant");
        wr_check(SP_SUP, 32'h0000_9998, 2'd3, 1'b0, "R10 allow mode dormant sup");
        block_mode = 1'b1;
        wr_check(SP_SUP, 32'h0000_0400, 2'd2, 1'b0, "R10 block mode dormant");
    endtask

    task automatic t_idle;
        reg_write(2'd0, 32'h0080_0010, 1'b0, "R11 re-enable seg0");
        reg_write(2'd1, 32'h0000_0020, 1'b0, "R11 restore upper");
        block_mode = 1'b0;
        @(negedge clk);
        chk_valid = 1'b0; chk_space = SP_USR; chk_addr = 32'h0000_0400; chk_size = 2'd2;
        #1;
        check("R11 no fault when idle", 32'(chk_fault), 32'h0);
        check("R11 no we when idle", 32'(mem_we), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        block_mode = 1'b0; chk_valid = 1'b0; chk_addr = '0;
        chk_space = '0; chk_size = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_block();
        t_allow();
        t_dword();
        t_parity();
        t_dormant();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule